// File: doc/BRIEF.md
# Indexed Host Register Bank for an Audio Converter

This block is the byte-wide host-side register file of an audio converter controller. The host sees only four locations, chosen by a 2-bit address and qualified by a select and separate read and write strobes. Location 0 holds a pointer. Location 1 is a window onto sixteen indirect control bytes, and the pointer's low nibble picks which one. Location 2 is a status byte. Location 3 carries sample data: a host write there fills a playback byte, and a host read there returns a capture byte.

The status byte combines one sticky interrupt flag with seven flags that the converter side reloads at each sample period. The interrupt flag sets on an event pulse while the interrupt enable is on, and it stays set until the host writes to the status location. Reserved bits in every register read as zero and cannot be written. One indirect byte returns a fixed revision code.

Top module: `hostreg_bank`

## Requirements
- R1: After reset the pointer reads 0x80 (only the init flag, bit 7, set), the status byte reads 0x00, `irq_o` is 0, and every writable indirect byte reads 0x00.
- R2: The pointer stores bits 7:5 and 3:0 of a write; bit 4 is reserved, so writing 0xFF reads back 0xEF.
- R3: A read or write at address 1 reaches the indirect byte numbered by pointer bits 3:0 as last written, and the other indirect bytes are left unchanged.
- R4: The writable bits of the indirect bytes are given by these masks: bytes 0–1 0xEF, bytes 2–5 0x9F, bytes 6–7 0xBF, byte 8 0xFF, byte 9 0xCF, byte 10 0xC2, byte 11 0x00, byte 12 0x00, byte 13 0xFD, bytes 14–15 0xFF. Bits outside a mask read 0 and ignore writes.
- R5: Indirect byte 12 reads {4'b0000, REV_ID} (default REV_ID 0xA), and writes do not change it.
- R6: A write at address 3 sets `pb_data_o` on the next cycle. A read at address 3 returns the capture byte, not the playback byte.
- R7: On each `smp_tick` cycle the capture byte loads `cap_in`. Between ticks it holds its value.
- R8: On each `smp_tick` cycle status bits 7:1 load `stat_in[6:0]`. Between ticks they hold their value.
- R9: Status bit 0 (the interrupt flag, mirrored on `irq_o`) sets one cycle after an `irq_evt` cycle only when indirect byte 10 bit 1 (the interrupt enable) is 1.
- R10: Once set, the interrupt flag stays set across sample ticks until the host writes anything to address 2, which clears it. If an event and a clearing write land in the same cycle, the flag ends up set.
- R11: `play_en_o` follows indirect byte 9 bit 0, and `cap_en_o` follows byte 9 bit 1.
- R12: With `sel` low, writes have no effect and `rdata` is 0x00. `rdata` is also 0x00 whenever `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| addr | input | 2 | Direct location number |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (combinational) |
| smp_tick | input | 1 | One-cycle sample-period strobe |
| stat_in | input | 7 | Fresh values for status bits 7:1 |
| cap_in | input | 8 | Capture sample byte from the converter |
| irq_evt | input | 1 | Interrupt event pulse |
| pb_data_o | output | 8 | Playback byte |
| play_en_o | output | 1 | Playback enable |
| cap_en_o | output | 1 | Capture enable |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions check several rules on every cycle. The interrupt flag holds unless the host clears it, and it rises only after an enabled event. The refreshed status bits and the pointer stay stable when they are not loaded. A playback write lands exactly one cycle later, and a read of byte 12 returns the revision code. Only the bench's directed scenarios show the following: reserved masks on each class of indirect byte, independence between indirect bytes through the pointer, the read/write split at address 3, the reset values, and that a clearing write loses to a simultaneous event.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

    localparam int DW    = 8;
    localparam int NIND  = 16;
    localparam int IW    = $clog2(NIND);

    localparam int REG_EN   = 9;
    localparam int REG_INTC = 10;
    localparam int REG_REV  = 12;

    localparam logic [DW-1:0] PTR_MASK  = 8'hEF;
    localparam logic [DW-1:0] PTR_RESET = 8'h80;

    typedef enum logic [1:0] {
        LOC_PTR  = 2'd0,
        LOC_WIN  = 2'd1,
        LOC_STAT = 2'd2,
        LOC_PIO  = 2'd3
    } loc_e;

    // writable bits of each indirect byte
    function automatic logic [DW-1:0] wmask(input logic [IW-1:0] n);
        logic [DW-1:0] m;
        case (n)
            4'd0, 4'd1:               m = 8'hEF;
            4'd2, 4'd3, 4'd4, 4'd5:   m = 8'h9F;
            4'd6, 4'd7:               m = 8'hBF;
            4'd8:                     m = 8'hFF;
            4'd9:                     m = 8'hCF;
            4'd10:                    m = 8'hC2;
            4'd13:                    m = 8'hFD;
            4'd14, 4'd15:             m = 8'hFF;
            default:                  m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hostreg_indirect.sv
module hostreg_indirect
    import hostreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    output logic [NIND-1:0][DW-1:0]  regs_o
);

    typedef struct packed {
        logic [NIND-1:0][DW-1:0] r;
    } ind_t;

    ind_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.r[waddr] = wdata & wmask(waddr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.r;

    // R3: untouched bytes stay put when no write
    assert_ind_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.r));

endmodule

// File: rtl/hostreg_status.sv
module hostreg_status
    import hostreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-2:0] fresh,
    input  logic          evt,
    input  logic          int_en,
    input  logic          clr,
    output logic [DW-1:0] stat_o
);

    typedef struct packed {
        logic [DW-2:0] flags;
        logic          intf;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.flags = fresh;
        end
        if (clr) begin
            st_d.intf = 1'b0;
        end
        if (evt && int_en) begin
            st_d.intf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = {st_q.flags, st_q.intf};

    assert_int_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.intf && !clr) |=> st_q.intf);

    assert_int_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.intf) |-> $past(evt && int_en));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.flags));

endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank
    import hostreg_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'hA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [1:0]    addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          smp_tick,
    input  logic [6:0]    stat_in,
    input  logic [7:0]    cap_in,
    input  logic          irq_evt,
    output logic [7:0]    pb_data_o,
    output logic          play_en_o,
    output logic          cap_en_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [DW-1:0] ptr;
        logic [DW-1:0] pb;
        logic [DW-1:0] cap;
    } top_t;

    top_t st_d, st_q;

    logic                    host_wr, host_rd;
    logic [NIND-1:0][DW-1:0] ind;
    logic [DW-1:0]           stat;
    logic [IW-1:0]           cur;
    logic [DW-1:0]           win_rd;

    assign host_wr = sel && wr;
    assign host_rd = sel && rd;
    assign cur     = st_q.ptr[IW-1:0];

    always_comb begin
        st_d = st_q;
        if (host_wr && addr == LOC_PTR) begin
            st_d.ptr = wdata & PTR_MASK;
        end
        if (host_wr && addr == LOC_PIO) begin
            st_d.pb = wdata;
        end
        if (smp_tick) begin
            st_d.cap = cap_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= PTR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    hostreg_indirect u_ind (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (host_wr && addr == LOC_WIN),
        .waddr  (cur),
        .wdata  (wdata),
        .regs_o (ind)
    );

    hostreg_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (smp_tick),
        .fresh  (stat_in),
        .evt    (irq_evt),
        .int_en (ind[REG_INTC][1]),
        .clr    (host_wr && addr == LOC_STAT),
        .stat_o (stat)
    );

    always_comb begin
        win_rd = ind[cur];
        if (cur == IW'(REG_REV)) begin
            win_rd = {4'b0000, REV_ID};
        end
    end

    always_comb begin
        rdata = '0;
        if (host_rd) begin
            case (addr)
                LOC_PTR:  rdata = st_q.ptr;
                LOC_WIN:  rdata = win_rd;
                LOC_STAT: rdata = stat;
                default:  rdata = st_q.cap;
            endcase
        end
    end

    assign pb_data_o = st_q.pb;
    assign play_en_o = ind[REG_EN][0];
    assign cap_en_o  = ind[REG_EN][1];
    assign irq_o     = stat[0];

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && addr == LOC_PTR) |=> $stable(st_q.ptr));

    assert_pio_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && addr == LOC_PIO) |=> (pb_data_o == $past(wdata)));

    assert_rev_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && addr == LOC_WIN && cur == IW'(REG_REV)) |-> (rdata == {4'b0000, REV_ID}));

    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> (rdata == 8'h00));

endmodule

// File: tb/sim_hostreg_bank.sv
`timescale 1ns/1ps
module sim_hostreg_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       smp_tick = 1'b0;
    logic [6:0] stat_in = 7'h00;
    logic [7:0] cap_in = 8'h00;
    logic       irq_evt = 1'b0;
    logic [7:0] pb_data_o;
    logic       play_en_o, cap_en_o, irq_o;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hostreg_bank u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .smp_tick(smp_tick), .stat_in(stat_in),
        .cap_in(cap_in), .irq_evt(irq_evt), .pb_data_o(pb_data_o),
        .play_en_o(play_en_o), .cap_en_o(cap_en_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1;
        chk(req, rdata, exp);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic ind_wr(input logic [3:0] n, input logic [7:0] d);
        bus_wr(2'd0, {4'h0, n});
        bus_wr(2'd1, d);
    endtask

    task automatic ind_rd(input logic [3:0] n, input logic [7:0] exp, input string req);
        bus_wr(2'd0, {4'h0, n});
        bus_rd(2'd1, exp, req);
    endtask

    task automatic tick(input logic [6:0] s, input logic [7:0] c);
        @(negedge clk);
        smp_tick = 1'b1; stat_in = s; cap_in = c;
        @(negedge clk);
        smp_tick = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0;
    endtask

    task automatic t_reset();
        bus_rd(2'd0, 8'h80, "R1 pointer reset");
        bus_rd(2'd2, 8'h00, "R1 status reset");
        #1 chk("R1 irq reset", {7'd0, irq_o}, 8'h00);
        ind_rd(4'd14, 8'h00, "R1 indirect reset");
        ind_rd(4'd12, 8'h0A, "R5 revision");
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, 8'h0A, "R5 revision write ignored");
    endtask

    task automatic t_pointer();
        bus_wr(2'd0, 8'hFF);
        bus_rd(2'd0, 8'hEF, "R2 pointer reserved bit");
    endtask

    task automatic t_indirect();
        ind_wr(4'd14, 8'hA5);
        ind_wr(4'd15, 8'h3C);
        ind_rd(4'd14, 8'hA5, "R3 byte 14 kept");
        ind_rd(4'd15, 8'h3C, "R3 byte 15");
        ind_wr(4'd0, 8'hFF);
        ind_rd(4'd0, 8'hEF, "R4 byte 0 mask");
        ind_wr(4'd3, 8'hFF);
        ind_rd(4'd3, 8'h9F, "R4 byte 3 mask");
        ind_wr(4'd10, 8'hFF);
        ind_rd(4'd10, 8'hC2, "R4 byte 10 mask");
        ind_wr(4'd11, 8'hFF);
        ind_rd(4'd11, 8'h00, "R4 byte 11 read-only");
    endtask

    task automatic t_pio();
        bus_wr(2'd3, 8'h77);
        #1 chk("R6 playback out", pb_data_o, 8'h77);
        bus_rd(2'd3, 8'h00, "R6 read returns capture");
        tick(7'h00, 8'h3E);
        bus_rd(2'd3, 8'h3E, "R7 capture load");
        @(negedge clk); cap_in = 8'hC1;
        bus_rd(2'd3, 8'h3E, "R7 capture hold");
    endtask

    task automatic t_status();
        tick(7'h55, 8'h00);
        bus_rd(2'd2, 8'hAA, "R8 status load");
        @(negedge clk); stat_in = 7'h2A;
        bus_rd(2'd2, 8'hAA, "R8 status hold");
    endtask

    task automatic t_irq();
        ind_wr(4'd10, 8'h00);
        pulse_evt();
        #1 chk("R9 disabled event", {7'd0, irq_o}, 8'h00);
        ind_wr(4'd10, 8'h02);
        pulse_evt();
        #1 chk("R9 enabled event", {7'd0, irq_o}, 8'h01);
        tick(7'h00, 8'h00);
        bus_rd(2'd2, 8'h01, "R10 sticky across tick");
        bus_wr(2'd2, 8'h00);
        #1 chk("R10 cleared by write", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 2'd2; irq_evt = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; irq_evt = 1'b0;
        #1 chk("R10 event beats clear", {7'd0, irq_o}, 8'h01);
        bus_wr(2'd2, 8'h00);
    endtask

    task automatic t_enables();
        ind_wr(4'd9, 8'h03);
        #1 chk("R11 both enables", {6'd0, cap_en_o, play_en_o}, 8'h03);
        ind_wr(4'd9, 8'h01);
        #1 chk("R11 playback only", {6'd0, cap_en_o, play_en_o}, 8'h01);
    endtask

    task automatic t_select();
        bus_wr(2'd0, 8'h0E);
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 8'h05;
        @(negedge clk);
        wr = 1'b0;
        bus_rd(2'd0, 8'h0E, "R12 unselected write ignored");
        @(negedge clk);
        sel = 1'b0; rd = 1'b1; addr = 2'd0;
        #1 chk("R12 unselected read zero", rdata, 8'h00);
        rd = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_pointer();
                t_indirect();
                t_pio();
                t_status();
                t_irq();
                t_enables();
                t_select();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule